// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

The watchdog counts state times, one state time being two system clock cycles, in a wide binary counter. A two-bit timeout code selects the counter stage whose overflow ends the period. When the period runs out, the block does one of two things. In the default mode it pulses a non-maskable interrupt request and sets a sticky source flag. With reset mode enabled it instead drives an internal chip reset pulse of fixed length. Healthy software keeps the watchdog quiet by writing a fixed clear code to a command port before the period runs out. That write restarts the count from zero.

After an overflow the counter wraps to zero and keeps running. The timeout code and the reset-mode bit are held in a mode register. Software can change that register at any time. A change applies to the running count and does not restart it. While the internal reset pulse is active, the counter is held at zero.

Top module: `wdog_timer`

## Requirements
- R1: The counter advances once every PRE_DIV (default 2) clock cycles. Timeout code n (0..3) gives a period of 2^(TAP_BASE + TAP_STEP*n) state times; with the defaults these are 2^15, 2^17, 2^19 and 2^21. The first overflow after a restart shows on the outputs exactly PRE_DIV * period clock edges after the restart edge.
- R2: In normal mode (cfg_rst_en = 0) each overflow raises nmi_req for exactly one cycle and sets nmi_flag.
- R3: nmi_flag stays set until a cycle with flag_clr = 1 clears it. An overflow in the same cycle as flag_clr wins, and the flag stays set.
- R4: After an overflow the counter wraps to zero and keeps counting. The next overflow follows one full period later.
- R5: A cycle with cmd_we = 1 and cmd_data = 8'h4E restarts the count and the state-time phase. A write of any other value has no effect on the count.
- R6: In reset mode (cfg_rst_en = 1) an overflow asserts chip_rst for RST_LEN (default 32) state times, which is 64 clock cycles. nmi_req and nmi_flag stay low.
- R7: While chip_rst is high the counter is held at zero. The next overflow follows one full period after chip_rst falls.
- R8: A write with cfg_we = 1 loads cfg_tap and cfg_rst_en without restarting the count. If the running count already meets or exceeds the newly selected period, the overflow occurs at the next state-time tick.
- R9: While rst_n is low the counter, the state-time phase, the flag and the reset pulse are cleared, and the mode returns to timeout code 0 with reset mode off. The first overflow then follows one period after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_tap | input | 2 | Timeout code to load |
| cfg_rst_en | input | 1 | Reset-mode enable to load |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte; 8'h4E restarts the count |
| flag_clr | input | 1 | Write-one clear of the interrupt source flag |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| nmi_flag | output | 1 | Sticky watchdog interrupt source flag |
| chip_rst | output | 1 | Internal reset pulse, active high |

## Verification
The restart edge is either the clear-code write or the last edge with reset low. nmi_req, nmi_flag and chip_rst all rise after the tick edge that ends the period, which is PRE_DIV times the period in clock edges after the restart edge. chip_rst falls 2*RST_LEN edges after it rises, and a tap change that lands on an overdue count shows two edges after the write. The bench drives inputs at the falling edge and counts rising edges from the edge that takes each write. It samples at the following falling edge, so every measured count equals the figure above with no slack.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic [1:0] tap;
    logic       rst_en;
  } wd_mode_t;

  // Period in state times for a timeout code.
  function automatic int unsigned wd_period(input logic [1:0] sel,
                                            input int unsigned base,
                                            input int unsigned step);
    return 32'd1 << (base + step * int'(sel));
  endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == PW'(PRE_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick) phase_q <= '0;
    else                           phase_q <= phase_q + 1'b1;
  end

  // R1: state-time ticks are never back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5: a restart drops the phase back so no tick follows at once
  assert_restart_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 22,
  parameter int TAP_BASE = 15,
  parameter int TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clear,
  input  logic       hold,
  input  logic [1:0] tap_sel,
  output logic       ovf_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit   = CNT_W'(wd_period(tap_sel, TAP_BASE, TAP_STEP) - 1);
  assign ovf_evt = tick && !hold && !clear && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || hold) cnt_q <= '0;
    else if (tick) begin
      if (ovf_evt) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: an overflow wraps the count to zero
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0));

  // R7: count is zero while the reset pulse holds it
  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));

  // R5: the clear code restarts from zero
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R1: the count only moves on a tick
  assert_count_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear && !hold) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int RST_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  output logic active
);
  localparam int RCW = $clog2(RST_LEN + 1);

  logic [RCW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 left_q <= '0;
    else if (fire)              left_q <= RCW'(RST_LEN);
    else if (tick && active)    left_q <= left_q - 1'b1;
  end

  // R6: the pulse only starts from an overflow in reset mode
  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(fire));

  // R6: a firing loads the full length
  assert_pulse_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (left_q == RCW'(RST_LEN)));

  // R6: the remaining length only shrinks on a tick
  assert_pulse_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !fire) |=> $stable(left_q));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int         CNT_W    = 22,
  parameter int         TAP_BASE = 15,
  parameter int         TAP_STEP = 2,
  parameter int         PRE_DIV  = 2,
  parameter int         RST_LEN  = 32,
  parameter logic [7:0] CLR_CODE = 8'h4E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_tap,
  input  logic       cfg_rst_en,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       flag_clr,
  output logic       nmi_req,
  output logic       nmi_flag,
  output logic       chip_rst
);
  wd_mode_t mode_q;
  logic     clear_hit;
  logic     tick;
  logic     ovf_evt;
  logic     nmi_evt;
  logic     rst_fire;
  logic     rst_active;
  logic     nmi_req_q;
  logic     nmi_flag_q;

  assign clear_hit = cmd_we && (cmd_data == CLR_CODE);
  assign nmi_evt   = ovf_evt && !mode_q.rst_en;
  assign rst_fire  = ovf_evt && mode_q.rst_en;

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= '{tap: 2'b00, rst_en: 1'b0};
    else if (cfg_we) mode_q <= '{tap: cfg_tap, rst_en: cfg_rst_en};
  end

  wdog_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(clear_hit), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear_hit),
    .hold(rst_active), .tap_sel(mode_q.tap), .ovf_evt(ovf_evt)
  );

  wdog_rstgen #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fire(rst_fire), .active(rst_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_req_q  <= 1'b0;
      nmi_flag_q <= 1'b0;
    end else begin
      nmi_req_q <= nmi_evt;
      if (nmi_evt)       nmi_flag_q <= 1'b1;
      else if (flag_clr) nmi_flag_q <= 1'b0;
    end
  end

  assign nmi_req  = nmi_req_q;
  assign nmi_flag = nmi_flag_q;
  assign chip_rst = rst_active;

  // R2: the request is a single-cycle pulse
  assert_nmi_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R2: every request comes with the flag set
  assert_nmi_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_flag);

  // R3: the flag only drops on a write-one clear
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !flag_clr) |=> nmi_flag);

  // R6: no interrupt request while the reset pulse is out
  assert_no_nmi_in_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> !nmi_req);

  // R8: mode loads only on its write strobe
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q));

endmodule

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  localparam int TB_BASE = 6;
  localparam int TB_STEP = 2;
  localparam int TB_RST  = 32;
  localparam int LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_tap = 2'b00;
  logic       cfg_rst_en = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic       nmi_req, nmi_flag, chip_rst;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  wdog_timer #(.CNT_W(12), .TAP_BASE(TB_BASE), .TAP_STEP(TB_STEP),
               .PRE_DIV(2), .RST_LEN(TB_RST), .CLR_CODE(8'h4E)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tap(cfg_tap),
    .cfg_rst_en(cfg_rst_en), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .flag_clr(flag_clr), .nmi_req(nmi_req), .nmi_flag(nmi_flag),
    .chip_rst(chip_rst)
  );

  // {tap, rst_en}
  localparam logic [2:0] VEC [6] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b001, 3'b011};

  function automatic int edges_for(input int tap);
    return 2 * (1 << (TB_BASE + TB_STEP * tap));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic cw, input logic [1:0] tp, input logic re,
                    input logic mw, input logic [7:0] d, input logic fc);
    cfg_we = cw; cfg_tap = tp; cfg_rst_en = re;
    cmd_we = mw; cmd_data = d; flag_clr = fc;
    step();
    cfg_we = 1'b0; cmd_we = 1'b0; flag_clr = 1'b0;
  endtask

  // sel 0: nmi_req, 1: chip_rst. Counts edges until the signal is seen high.
  task automatic wait_hi(input int sel, input int start, output int n, output int nmi_seen);
    n = start;
    nmi_seen = 0;
    for (int i = 0; i < LIMIT; i++) begin
      step();
      n++;
      if (nmi_req) nmi_seen = 1;
      if ((sel == 0) ? nmi_req : chip_rst) return;
    end
    n = -1;
  endtask

  task automatic width_hi(output int w);
    w = 0;
    while (chip_rst && w < LIMIT) begin
      step();
      w++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, w, sn;
    repeat (3) @(negedge clk);
    chk("R9 nmi_req after reset", int'(nmi_req), 0);
    chk("R9 nmi_flag after reset", int'(nmi_flag), 0);
    chk("R9 chip_rst after reset", int'(chip_rst), 0);
    rst_n = 1'b1;
    // R9: default mode is code 0, normal mode
    wait_hi(0, 0, n, sn);
    chk("R9 first overflow after release", n, edges_for(0));
    chk("R9 default mode no reset", int'(chip_rst), 0);
    wr(1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1);

    // table walk
    foreach (VEC[k]) begin
      int tp;
      int re;
      tp = int'(VEC[k][2:1]);
      re = int'(VEC[k][0]);
      wr(1'b1, VEC[k][2:1], VEC[k][0], 1'b1, 8'h4E, 1'b1);
      if (re == 0) begin
        wait_hi(0, 0, n, sn);
        chk("R1 period for timeout code", n, edges_for(tp));
        chk("R2 flag set with request", int'(nmi_flag), 1);
        step();
        chk("R2 request is one cycle", int'(nmi_req), 0);
        if (tp == 0) begin
          wait_hi(0, 1, n, sn);
          chk("R4 wrap gives a full period", n, edges_for(0));
          // R3: flag still set with no clear
          idle(20);
          chk("R3 flag sticky", int'(nmi_flag), 1);
          wr(1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1);
          chk("R3 flag cleared by write one", int'(nmi_flag), 0);
        end
        wr(1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1);
      end else begin
        wait_hi(1, 0, n, sn);
        chk("R6 reset pulse after period", n, edges_for(tp));
        chk("R6 no flag in reset mode", int'(nmi_flag), 0);
        chk("R6 no request in reset mode", sn, 0);
        width_hi(w);
        chk("R6 pulse width", w, 2 * TB_RST);
        wait_hi(1, 0, n, sn);
        chk("R7 period restarts after pulse", n, edges_for(tp));
        width_hi(w);
      end
    end

    // R5: wrong code has no effect
    wr(1'b1, 2'b00, 1'b0, 1'b1, 8'h4E, 1'b1);
    idle(49);
    wr(1'b0, 2'b00, 1'b0, 1'b1, 8'h4F, 1'b0);
    wait_hi(0, 50, n, sn);
    chk("R5 wrong code ignored", n, edges_for(0));
    // R5: right code mid-count restarts
    wr(1'b0, 2'b00, 1'b0, 1'b1, 8'h4E, 1'b1);
    idle(49);
    wr(1'b0, 2'b00, 1'b0, 1'b1, 8'h4E, 1'b0);
    wait_hi(0, 50, n, sn);
    chk("R5 clear code restarts", n, 50 + edges_for(0));

    // R8: widen the period mid-count, no restart
    wr(1'b1, 2'b00, 1'b0, 1'b1, 8'h4E, 1'b1);
    idle(99);
    wr(1'b1, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0);
    wait_hi(0, 100, n, sn);
    chk("R8 tap change keeps count", n, edges_for(1));
    // R8: narrow the period below the running count
    wr(1'b1, 2'b01, 1'b0, 1'b1, 8'h4E, 1'b1);
    idle(299);
    wr(1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0);
    wait_hi(0, 300, n, sn);
    chk("R8 overdue count fires at next tick", n, 302);

    // R9: reset during a reset pulse
    wr(1'b1, 2'b00, 1'b1, 1'b1, 8'h4E, 1'b1);
    wait_hi(1, 0, n, sn);
    idle(5);
    rst_n = 1'b0;
    step();
    chk("R9 reset ends pulse", int'(chip_rst), 0);
    rst_n = 1'b1;
    wait_hi(0, 0, n, sn);
    chk("R9 mode back to normal", n, edges_for(0));
    chk("R9 no pulse after reset", int'(chip_rst), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule